// File: doc/BRIEF.md
# Synchronous USB Bridge Transmit Writer

This block moves 32-bit words from an on-chip first-word-fall-through buffer into an external USB bridge chip that runs a synchronous, byte-parallel FIFO handshake. All of its logic runs on the clock that the bridge supplies. The bridge pulls its active-low "ready to take data" input low when the host asks for data. The block then waits a fixed settling time and drives its active-low write strobe together with a registered data word. Every byte lane is always enabled, so each transfer carries a full word.

The block pops the upstream buffer only when it loads a word into its output register. If the bridge withdraws readiness while a word is on the bus, the block keeps that word and presents it again when writing resumes. Every buffered word therefore reaches the bridge once, in order. When the buffer runs dry, the strobe rises and the block waits for more data.

Top module: `usbw_sync_tx`

## Requirements
- R1: The byte-enable output `lane_en_o` is all ones in every cycle, including during reset.
- R2: While `rst_ni` is low at a clock edge, the outputs after that edge are: `strobe_n_o` high, `bus_data_o` zero, and `src_pop_o` low.
- R3: `strobe_n_o` goes low only after `bridge_rdy_n_i` has been sampled low on at least WAIT_CYC+1 consecutive edges (three with the default WAIT_CYC=2). The strobe falls at the third such edge, which is two cycles after the first low sample.
- R4: A word is transferred on every edge at which `strobe_n_o` and `bridge_rdy_n_i` are both low. While the bridge stays ready and the buffer is not empty, a new word is presented after each transfer with no idle cycle between them.
- R5: `src_pop_o` is high only in a cycle where the bridge is ready, the wait has elapsed, the buffer is not empty, and the output register is free or is being emptied at that edge. It is never high while `src_empty_i` is high.
- R6: If `bridge_rdy_n_i` is sampled high while the strobe is low, the strobe is high after that edge. The word that was not accepted stays on `bus_data_o` unchanged and is sent first when writing resumes.
- R7: When no word is pending and the buffer is empty, the strobe is high after the next edge.
- R8: After readiness has been withdrawn, the full wait of R3 applies again before the strobe can fall.
- R9: Words reach the bridge in the order they were popped, each exactly once. `bus_data_o` holds its last value while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge-supplied clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bridge_rdy_n_i | input | 1 | Active-low: bridge can accept data |
| src_data_i | input | 32 | Head word of the upstream first-word-fall-through buffer |
| src_empty_i | input | 1 | Upstream buffer is empty |
| src_pop_o | output | 1 | Consume the head word at this edge |
| bus_data_o | output | 32 | Data bus to the bridge |
| strobe_n_o | output | 1 | Active-low write strobe |
| lane_en_o | output | 4 | Byte enables, always all ones |

## Verification
The strobe and the data bus are registered, so each responds at the edge that samples the causing input. The results are visible from just after that edge. The pop request is combinational and is due in the same cycle as the inputs that cause it. The bench drives its inputs and compares against a behavioural model on the falling edge. The model keeps a count of consecutive ready samples and a pending word, and it steps with each rising edge. Each output is therefore compared in the cycle it is due. Words accepted by the modelled bridge are scored against the push order, which catches loss and duplication across withdrawals.

// File: rtl/usbw_pkg.sv
// Package: shared widths for the USB bridge transmit writer.
// Assumes the word width is a whole number of bytes.
package usbw_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned WAIT_CY = 2;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;
endpackage

// File: rtl/usbw_ready_timer.sv
// Module: usbw_ready_timer
// Counts consecutive edges at which the bridge reports ready and flags when the
// settling wait has elapsed. Assumes the ready input is already synchronous to clk_i.
module usbw_ready_timer #(
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rdy_n_i,
    output logic go_o
);
    localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1) + 1;

    logic [CNT_W-1:0] run_q;

    // Run length of low samples, saturating at WAIT_CYC, cleared when high.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (rdy_n_i) begin
            run_q <= '0;
        end else if (run_q != CNT_W'(WAIT_CYC)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Writing permitted at this edge: ready now and the wait has passed.
    always_comb begin
        go_o = !rdy_n_i && (run_q == CNT_W'(WAIT_CYC));
    end

    p_go_needs_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_o |-> !rdy_n_i);
endmodule

// File: rtl/usbw_out_stage.sv
// Module: usbw_out_stage
// One-word output register toward the bridge. It loads from a first-word-fall-through
// source and keeps a word the bridge did not accept until it is accepted.
// Assumes go_i is only high while the bridge is ready.
module usbw_out_stage #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic              rdy_n_i,
    input  logic [WORD_W-1:0] src_data_i,
    input  logic              src_empty_i,
    output logic              pop_o,
    output logic [WORD_W-1:0] data_o,
    output logic              strobe_n_o
);
    localparam int unsigned LANES = WORD_W / 8;

    logic hold_q;
    logic strobe_n_q;
    logic taken;
    logic keep;
    logic load;
    logic hold_d;

    // Decide transfer, retention and refill for this edge.
    always_comb begin
        taken = !strobe_n_q && !rdy_n_i;
        keep  = hold_q && !taken;
        load  = go_i && !keep && !src_empty_i;
        hold_d = keep || load;
    end

    // Pending-word flag and write strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hold_q     <= 1'b0;
            strobe_n_q <= 1'b1;
        end else begin
            hold_q     <= hold_d;
            strobe_n_q <= !(go_i && hold_d);
        end
    end

    // Per-byte data register, refilled only when a word is loaded.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] byte_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                byte_q <= '0;
            end else if (load) begin
                byte_q <= src_data_i[8*g +: 8];
            end
        end
        assign data_o[8*g +: 8] = byte_q;
    end

    assign pop_o      = load;
    assign strobe_n_o = strobe_n_q;

    p_no_pop_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_o |-> !src_empty_i);
    p_drop_on_withdraw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!strobe_n_o && rdy_n_i) |=> strobe_n_o);
    p_keep_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!strobe_n_o && rdy_n_i) |=> $stable(data_o));
    p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_n_o && !pop_o) |=> $stable(data_o));
endmodule

// File: rtl/usbw_sync_tx.sv
// Module: usbw_sync_tx (top)
// Streams words from a first-word-fall-through buffer into a USB bridge running a
// synchronous FIFO handshake, with a fixed wait after the bridge signals ready.
// Assumes every input is synchronous to the bridge clock clk_i.
module usbw_sync_tx
    import usbw_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bridge_rdy_n_i,
    input  logic [31:0] src_data_i,
    input  logic        src_empty_i,
    output logic        src_pop_o,
    output logic [31:0] bus_data_o,
    output logic        strobe_n_o,
    output logic [3:0]  lane_en_o
);
    logic go;

    usbw_ready_timer #(.WAIT_CYC(WAIT_CY)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rdy_n_i (bridge_rdy_n_i),
        .go_o    (go)
    );

    usbw_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .go_i        (go),
        .rdy_n_i     (bridge_rdy_n_i),
        .src_data_i  (src_data_i),
        .src_empty_i (src_empty_i),
        .pop_o       (src_pop_o),
        .data_o      (bus_data_o),
        .strobe_n_o  (strobe_n_o)
    );

    // Full-word transfers only: every byte lane enabled.
    assign lane_en_o = '1;

    // Checker counter: consecutive ready samples, independent of the timer.
    logic [7:0] chk_run_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni || bridge_rdy_n_i) begin
            chk_run_q <= '0;
        end else if (chk_run_q != 8'hFF) begin
            chk_run_q <= chk_run_q + 1'b1;
        end
    end

    p_lanes_on_r1: assert property (@(posedge clk_i) lane_en_o == '1);
    p_wait_seen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_n_o |-> (chk_run_q > 8'(WAIT_CY)));
    p_rewait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(strobe_n_o) |-> $past(!bridge_rdy_n_i));
    p_reset_state_r2: assert property (@(posedge clk_i)
        !rst_ni |=> (strobe_n_o && bus_data_o == '0));
endmodule

// File: tb/usbw_sync_tx_tb.sv
module usbw_sync_tx_tb;
    localparam int WAIT = 2;
    localparam logic [31:0] BASE = 32'hA5C0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdy_n = 1'b1;
    logic [31:0] src_data = '0;
    logic        src_empty = 1'b1;
    logic        pop;
    logic [31:0] bus;
    logic        strobe_n;
    logic [3:0]  lanes;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] q[$];
    int pushed = 0;
    int rx_cnt = 0;

    int          lowcnt = 0;
    bit          pend = 1'b0;
    bit          exp_wr_n = 1'b1;
    logic [31:0] exp_data = '0;

    always #4 clk = ~clk;

    usbw_sync_tx u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .bridge_rdy_n_i (rdy_n),
        .src_data_i     (src_data),
        .src_empty_i    (src_empty),
        .src_pop_o      (pop),
        .bus_data_o     (bus),
        .strobe_n_o     (strobe_n),
        .lane_en_o      (lanes)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic refresh_src();
        src_empty = (q.size() == 0);
        src_data  = (q.size() != 0) ? q[0] : 32'h0;
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            q.push_back(BASE + 32'(pushed));
            pushed++;
        end
        refresh_src();
    endtask

    // One clock: compare at the falling edge, then advance the model across the rising edge.
    task automatic step();
        bit ready, acc, epop;
        #1;
        ready = (rdy_n == 1'b0) && (lowcnt >= WAIT);
        acc   = (exp_wr_n == 1'b0) && (rdy_n == 1'b0);
        epop  = ready && !(pend && !acc) && (q.size() > 0);
        chk(strobe_n == exp_wr_n, "R3 R6 R7 R8 strobe", 32'(strobe_n), 32'(exp_wr_n));
        chk(bus == exp_data, "R9 R6 data bus", bus, exp_data);
        chk(lanes == 4'hF, "R1 lane enables", 32'(lanes), 32'hF);
        chk(pop == epop, "R5 R4 pop", 32'(pop), 32'(epop));
        if (acc) begin
            chk(bus == BASE + 32'(rx_cnt), "R9 R4 order", bus, BASE + 32'(rx_cnt));
            rx_cnt++;
        end
        pend = (pend && !acc) || epop;
        if (epop) exp_data = q[0];
        lowcnt = rdy_n ? 0 : lowcnt + 1;
        exp_wr_n = !(ready && pend);
        @(posedge clk);
        #1;
        if (epop) void'(q.pop_front());
        refresh_src();
        @(negedge clk);
    endtask

    task automatic run(input bit r, input int n);
        rdy_n = r;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(strobe_n == 1'b1, "R2 reset strobe", 32'(strobe_n), 32'h1);
        chk(bus == 32'h0, "R2 reset data", bus, 32'h0);
        chk(pop == 1'b0, "R2 reset pop", 32'(pop), 32'h0);
        chk(lanes == 4'hF, "R1 reset lanes", 32'(lanes), 32'hF);
        rst_n = 1'b1;
        run(1'b1, 3);
        // Streaming burst then drain to empty (R4, R7).
        push(5);
        run(1'b0, 12);
        run(1'b1, 2);
        // Withdrawal mid-burst and resume (R6, R8).
        push(6);
        run(1'b0, 4);
        run(1'b1, 3);
        run(1'b0, 10);
        run(1'b1, 1);
        // Ready while empty, data arrives later (R5, R7).
        run(1'b0, 5);
        push(3);
        run(1'b0, 6);
        run(1'b1, 1);
        // Short ready pulses never reach the strobe (R3, R8).
        push(4);
        for (int i = 0; i < 4; i++) begin
            run(1'b0, 1);
            run(1'b1, 1);
        end
        run(1'b0, 2);
        run(1'b1, 1);
        run(1'b0, 10);
        // Withdrawal on the first strobe cycle (R6).
        push(2);
        run(1'b1, 1);
        run(1'b0, 3);
        run(1'b1, 2);
        run(1'b0, 6);
        run(1'b1, 2);
        chk(rx_cnt == pushed, "R9 all words delivered once", 32'(rx_cnt), 32'(pushed));
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule